// File: doc/BRIEF.md
# Parallel NOR Flash Identification Reader

This controller fetches the identification of a parallel NOR flash array that sits on a simple synchronous memory bus. The array may be built from several identical devices placed side by side on one bus word. A single-cycle start pulse launches a fixed command script: an unlock pair, an identify-mode entry, two reads for the manufacturer and device codes, and optionally two further reads. It ends with a return-to-array command. When the script completes, the controller raises a one-cycle done strobe. At that moment the manufacturer byte and a 32-bit device identifier are valid on its outputs.

Only the lowest device lane of each read word is used. The device code is cut to one lane's width. Some devices answer with an escape code, meaning that their real code spans three bytes. In that case the controller reads two more locations and packs a 24-bit identifier. Every command byte is written to all device lanes at once, so all devices change mode together.

Each bus step holds its strobe, address and write data until the bus returns an acknowledge. Any number of wait states is therefore tolerated.

Top module: `nor_id_reader`

## Requirements
- R1: After an accepted start, the first three bus transactions are writes, to word offsets 0x555, 0x2AA and 0x555 in that order, carrying command bytes 0xAA, 0x55 and 0x90.
- R2: Every command byte is written zero-extended into each device lane of the bus word. Lane width is BUS_W/DEV_CNT; with the defaults (32-bit bus, 2 devices) 0xAA appears as 0x00AA00AA.
- R3: The fourth transaction reads offset 0x000; bits [7:0] of the returned word become the manufacturer output.
- R4: The fifth transaction reads offset 0x001; the returned word is masked to its lowest lane (bits [LANE_W-1:0], zero-extended to 32 bits); other lanes have no effect.
- R5: When the masked device code equals 0x0000007E, offsets 0x00E then 0x00F are read, and the identifier becomes 0x7E<<16 | (byte [7:0] of the 0x00E word)<<8 | (byte [7:0] of the 0x00F word).
- R6: When the masked device code is any other value (including values whose low byte is 0x7E), no extra reads occur and the identifier equals the masked code; the run has exactly six transactions.
- R7: The last transaction of every run is a write of command byte 0xF0 (per lane) to offset 0x555.
- R8: A pending transaction keeps its address, data and strobe unchanged until the acknowledge is sampled, and the write and read strobes are never high together.
- R9: busy goes high on the clock edge that accepts start; done is high for exactly one cycle, one cycle after the last acknowledge, with the identifier valid; busy falls on the following cycle.
- R10: A start pulse that arrives while busy is high has no effect: no extra transactions and no second run.
- R11: After reset the block is idle: busy, done and both strobes low, identifier and manufacturer zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| busy_o | output | 1 | High while the command script runs |
| done_o | output | 1 | One-cycle completion strobe |
| id_o | output | 32 | Device identifier |
| mfr_o | output | 8 | Manufacturer byte |
| bus_addr_o | output | ADDR_W | Word address |
| bus_wdata_o | output | BUS_W | Write data |
| bus_we_o | output | 1 | Write strobe |
| bus_re_o | output | 1 | Read strobe |
| bus_rdata_i | input | BUS_W | Read data, valid with acknowledge |
| bus_ack_i | input | 1 | Transaction acknowledge |

## Verification
The hardest condition to reach from the ports is the extended-identifier branch while the upper device lane carries unrelated data. That is the only situation that proves both the lane mask and the escape comparison. The bench's bus model answers the device-code read with a word whose lowest lane is 0x007E and whose upper lane is all ones. A second run returns a lowest lane of 0x227E, to show that a matching low byte alone does not trigger the escape. Wait states are set per run, so that both the hold rule and back-to-back acknowledges are exercised.

// File: rtl/nor_id_pkg.sv
package nor_id_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_UNLOCK_A,
        ST_UNLOCK_B,
        ST_ENTER_ID,
        ST_RD_MFR,
        ST_RD_DEV,
        ST_RD_EXT_HI,
        ST_RD_EXT_LO,
        ST_EXIT,
        ST_FINISH
    } step_e;

    typedef struct packed {
        logic        wr;
        logic        rd;
        logic [11:0] off;
        logic [7:0]  code;
    } bus_op_t;

    localparam logic [7:0]  CMD_UNLOCK_A = 8'hAA;
    localparam logic [7:0]  CMD_UNLOCK_B = 8'h55;
    localparam logic [7:0]  CMD_ENTER_ID = 8'h90;
    localparam logic [7:0]  CMD_EXIT     = 8'hF0;

    localparam logic [11:0] OFF_CMD_A    = 12'h555;
    localparam logic [11:0] OFF_CMD_B    = 12'h2AA;
    localparam logic [11:0] OFF_MFR      = 12'h000;
    localparam logic [11:0] OFF_DEV      = 12'h001;
    localparam logic [11:0] OFF_EXT_HI   = 12'h00E;
    localparam logic [11:0] OFF_EXT_LO   = 12'h00F;

    localparam logic [31:0] DEV_ESCAPE   = 32'h0000_007E;

endpackage

// File: rtl/nor_id_step_decode.sv
module nor_id_step_decode
    import nor_id_pkg::*;
(
    input  step_e   step_i,
    output bus_op_t op_o
);

    always_comb begin
        op_o = '{wr: 1'b0, rd: 1'b0, off: 12'h000, code: 8'h00};
        case (step_i)
            ST_UNLOCK_A:  op_o = '{wr: 1'b1, rd: 1'b0, off: OFF_CMD_A,  code: CMD_UNLOCK_A};
            ST_UNLOCK_B:  op_o = '{wr: 1'b1, rd: 1'b0, off: OFF_CMD_B,  code: CMD_UNLOCK_B};
            ST_ENTER_ID:  op_o = '{wr: 1'b1, rd: 1'b0, off: OFF_CMD_A,  code: CMD_ENTER_ID};
            ST_RD_MFR:    op_o = '{wr: 1'b0, rd: 1'b1, off: OFF_MFR,    code: 8'h00};
            ST_RD_DEV:    op_o = '{wr: 1'b0, rd: 1'b1, off: OFF_DEV,    code: 8'h00};
            ST_RD_EXT_HI: op_o = '{wr: 1'b0, rd: 1'b1, off: OFF_EXT_HI, code: 8'h00};
            ST_RD_EXT_LO: op_o = '{wr: 1'b0, rd: 1'b1, off: OFF_EXT_LO, code: 8'h00};
            ST_EXIT:      op_o = '{wr: 1'b1, rd: 1'b0, off: OFF_CMD_A,  code: CMD_EXIT};
            default:      op_o = '{wr: 1'b0, rd: 1'b0, off: 12'h000, code: 8'h00};
        endcase
    end

endmodule

// File: rtl/nor_id_lanes.sv
module nor_id_lanes #(
    parameter int BUS_W   = 32,
    parameter int DEV_CNT = 2
) (
    input  logic [7:0]       code_i,
    output logic [BUS_W-1:0] wdata_o,
    input  logic [BUS_W-1:0] rdata_i,
    output logic [31:0]      lane0_o
);

    localparam int LANE_W = BUS_W / DEV_CNT;

    for (genvar g = 0; g < DEV_CNT; g++) begin : g_rep
        assign wdata_o[g*LANE_W +: LANE_W] = LANE_W'(code_i);
    end

    if (LANE_W >= 32) begin : g_full
        assign lane0_o = rdata_i[31:0];
    end else begin : g_part
        assign lane0_o = {{(32-LANE_W){1'b0}}, rdata_i[LANE_W-1:0]};
    end

    if (BUS_W > 32 || LANE_W < BUS_W) begin : g_spare
        localparam int USED = (LANE_W >= 32) ? 32 : LANE_W;
        logic unused_upper;
        assign unused_upper = ^rdata_i[BUS_W-1:USED];
    end

endmodule

// File: rtl/nor_id_ctrl.sv
module nor_id_ctrl
    import nor_id_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        ack_i,
    input  logic [31:0] lane0_i,
    output step_e       step_o,
    output logic        busy_o,
    output logic        done_o,
    output logic [31:0] id_o,
    output logic [7:0]  mfr_o
);

    typedef struct packed {
        step_e       step;
        logic [7:0]  mfr;
        logic [31:0] id;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (st_q.step)
            ST_IDLE: begin
                if (start_i) st_d.step = ST_UNLOCK_A;
            end
            ST_FINISH: begin
                st_d.step = ST_IDLE;
            end
            default: begin
                if (ack_i) begin
                    case (st_q.step)
                        ST_UNLOCK_A: st_d.step = ST_UNLOCK_B;
                        ST_UNLOCK_B: st_d.step = ST_ENTER_ID;
                        ST_ENTER_ID: st_d.step = ST_RD_MFR;
                        ST_RD_MFR: begin
                            st_d.mfr  = lane0_i[7:0];
                            st_d.step = ST_RD_DEV;
                        end
                        ST_RD_DEV: begin
                            if (lane0_i == DEV_ESCAPE) begin
                                st_d.id   = DEV_ESCAPE << 16;
                                st_d.step = ST_RD_EXT_HI;
                            end else begin
                                st_d.id   = lane0_i;
                                st_d.step = ST_EXIT;
                            end
                        end
                        ST_RD_EXT_HI: begin
                            st_d.id[15:8] = lane0_i[7:0];
                            st_d.step     = ST_RD_EXT_LO;
                        end
                        ST_RD_EXT_LO: begin
                            st_d.id[7:0] = lane0_i[7:0];
                            st_d.step    = ST_EXIT;
                        end
                        ST_EXIT:  st_d.step = ST_FINISH;
                        default:  st_d.step = ST_IDLE;
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{step: ST_IDLE, mfr: 8'h00, id: 32'h0};
        end else begin
            st_q <= st_d;
        end
    end

    assign step_o = st_q.step;
    assign busy_o = (st_q.step != ST_IDLE);
    assign done_o = (st_q.step == ST_FINISH);
    assign id_o   = st_q.id;
    assign mfr_o  = st_q.mfr;

endmodule

// File: rtl/nor_id_reader.sv
module nor_id_reader
    import nor_id_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int BUS_W   = 32,
    parameter int DEV_CNT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [31:0]       id_o,
    output logic [7:0]        mfr_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [BUS_W-1:0]  bus_wdata_o,
    output logic              bus_we_o,
    output logic              bus_re_o,
    input  logic [BUS_W-1:0]  bus_rdata_i,
    input  logic              bus_ack_i
);

    step_e       step;
    bus_op_t     op;
    logic [31:0] lane0;

    nor_id_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .ack_i   (bus_ack_i),
        .lane0_i (lane0),
        .step_o  (step),
        .busy_o  (busy_o),
        .done_o  (done_o),
        .id_o    (id_o),
        .mfr_o   (mfr_o)
    );

    nor_id_step_decode u_dec (
        .step_i (step),
        .op_o   (op)
    );

    nor_id_lanes #(
        .BUS_W   (BUS_W),
        .DEV_CNT (DEV_CNT)
    ) u_lanes (
        .code_i  (op.code),
        .wdata_o (bus_wdata_o),
        .rdata_i (bus_rdata_i),
        .lane0_o (lane0)
    );

    assign bus_addr_o = ADDR_W'(op.off);
    assign bus_we_o   = op.wr;
    assign bus_re_o   = op.rd;

endmodule

// File: rtl/nor_id_checker.sv
module nor_id_checker #(
    parameter int ADDR_W = 20,
    parameter int BUS_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [ADDR_W-1:0] bus_addr_o,
    input logic [BUS_W-1:0]  bus_wdata_o,
    input logic              bus_we_o,
    input logic              bus_re_o,
    input logic              bus_ack_i
);

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we_o && bus_re_o)); // R8

    AST_HOLD_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_we_o || bus_re_o) && !bus_ack_i) |=>
        ($stable(bus_addr_o) && $stable(bus_wdata_o) && $stable(bus_we_o) && $stable(bus_re_o))); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (busy_o && !bus_we_o && !bus_re_o)); // R9

    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o); // R9

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!bus_we_o && !bus_re_o && !done_o)); // R11

endmodule

bind nor_id_reader nor_id_checker #(
    .ADDR_W (ADDR_W),
    .BUS_W  (BUS_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o),
    .bus_we_o    (bus_we_o),
    .bus_re_o    (bus_re_o),
    .bus_ack_i   (bus_ack_i)
);

// File: tb/tb_nor_id_reader.sv
`timescale 1ns/1ps
module tb_nor_id_reader;

    localparam int ADDR_W  = 20;
    localparam int BUS_W   = 32;
    localparam int DEV_CNT = 2;
    localparam int LANE_W  = BUS_W / DEV_CNT;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              busy, done;
    logic [31:0]       id;
    logic [7:0]        mfr;
    logic [ADDR_W-1:0] addr;
    logic [BUS_W-1:0]  wdata;
    logic              we, re;
    logic [BUS_W-1:0]  rdata;
    logic              ack;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    nor_id_reader #(
        .ADDR_W (ADDR_W), .BUS_W (BUS_W), .DEV_CNT (DEV_CNT)
    ) dut (
        .clk (clk), .rst_n (rst_n), .start_i (start),
        .busy_o (busy), .done_o (done), .id_o (id), .mfr_o (mfr),
        .bus_addr_o (addr), .bus_wdata_o (wdata), .bus_we_o (we), .bus_re_o (re),
        .bus_rdata_i (rdata), .bus_ack_i (ack)
    );

    // bus model
    logic [BUS_W-1:0] m_mfr, m_dev, m_ehi, m_elo;
    int               lat = 0;
    int               wcnt = 0;
    logic [ADDR_W-1:0] lg_addr [0:63];
    logic [BUS_W-1:0]  lg_data [0:63];
    logic              lg_wr   [0:63];
    int                lg_n = 0;
    int                hold_err = 0;
    int                excl_err = 0;
    logic [ADDR_W-1:0] p_addr;
    logic [BUS_W-1:0]  p_wdata;
    logic              p_we = 1'b0, p_re = 1'b0, p_ack = 1'b0;

    function automatic logic [BUS_W-1:0] lookup(input logic [ADDR_W-1:0] a);
        case (a)
            20'h00000: return m_mfr;
            20'h00001: return m_dev;
            20'h0000E: return m_ehi;
            20'h0000F: return m_elo;
            default:   return '1;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack   <= 1'b0;
            rdata <= '0;
            wcnt  <= 0;
        end else if ((we || re) && !ack) begin
            if (wcnt >= lat) begin
                ack   <= 1'b1;
                rdata <= re ? lookup(addr) : '0;
                wcnt  <= 0;
                if (lg_n < 64) begin
                    lg_addr[lg_n] <= addr;
                    lg_data[lg_n] <= wdata;
                    lg_wr[lg_n]   <= we;
                end
                lg_n <= lg_n + 1;
            end else begin
                wcnt <= wcnt + 1;
            end
        end else begin
            ack <= 1'b0;
        end
    end

    always @(posedge clk) begin
        if (rst_n) begin
            if (we && re) excl_err = excl_err + 1;
            if ((p_we || p_re) && !p_ack &&
                (addr != p_addr || wdata != p_wdata || we != p_we || re != p_re))
                hold_err = hold_err + 1;
        end
        p_addr  = addr;
        p_wdata = wdata;
        p_we    = we;
        p_re    = re;
        p_ack   = ack;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [BUS_W-1:0] rep(input logic [7:0] c);
        logic [BUS_W-1:0] w;
        for (int g = 0; g < DEV_CNT; g++) w[g*LANE_W +: LANE_W] = LANE_W'(c);
        return w;
    endfunction

    function automatic logic [31:0] lane0(input logic [BUS_W-1:0] w);
        return 32'(w[LANE_W-1:0]);
    endfunction

    // runs one identification; optionally pulses start mid-run
    task automatic run(input int wait_states, input bit mid_start,
                       output logic [31:0] got_id, output logic [7:0] got_mfr,
                       output int base, output int n);
        int k;
        lat = wait_states;
        @(negedge clk);
        base  = lg_n;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R9 busy after start", 32'(busy), 32'd1);
        k = 0;
        while (!done && k < 2000) begin
            @(negedge clk);
            k++;
            if (mid_start && k == 4) start = 1'b1;
            else start = 1'b0;
        end
        start = 1'b0;
        chk("R9 done seen", 32'(done), 32'd1);
        got_id  = id;
        got_mfr = mfr;
        @(negedge clk);
        chk("R9 done one cycle", 32'(done), 32'd0);
        chk("R9 busy falls", 32'(busy), 32'd0);
        n = lg_n - base;
    endtask

    task automatic check_seq(input int base, input int n, input bit ext);
        logic [ADDR_W-1:0] ea [0:7];
        logic              ew [0:7];
        logic [7:0]        ec [0:7];
        int                en;
        ea[0] = 20'h555; ew[0] = 1; ec[0] = 8'hAA;
        ea[1] = 20'h2AA; ew[1] = 1; ec[1] = 8'h55;
        ea[2] = 20'h555; ew[2] = 1; ec[2] = 8'h90;
        ea[3] = 20'h000; ew[3] = 0; ec[3] = 8'h00;
        ea[4] = 20'h001; ew[4] = 0; ec[4] = 8'h00;
        if (ext) begin
            ea[5] = 20'h00E; ew[5] = 0; ec[5] = 8'h00;
            ea[6] = 20'h00F; ew[6] = 0; ec[6] = 8'h00;
            en = 8;
        end else begin
            en = 6;
        end
        ea[en-1] = 20'h555; ew[en-1] = 1; ec[en-1] = 8'hF0;
        chk(ext ? "R5 transaction count" : "R6 transaction count", 32'(n), 32'(en));
        for (int i = 0; i < en && i < n; i++) begin
            chk(i < 3 ? "R1 address" : (i == en-1 ? "R7 address" : "R4 R5 read address"),
                32'(lg_addr[base+i]), 32'(ea[i]));
            chk(i < 3 ? "R1 direction" : "R7 direction", 32'(lg_wr[base+i]), 32'(ew[i]));
            if (ew[i])
                chk(i < 3 ? "R2 lane data" : "R7 exit data", lg_data[base+i], rep(ec[i]));
        end
    endtask

    task automatic t_reset;
        chk("R11 busy", 32'(busy), 32'd0);
        chk("R11 done", 32'(done), 32'd0);
        chk("R11 strobes", 32'({we, re}), 32'd0);
        chk("R11 id", id, 32'd0);
        chk("R11 mfr", 32'(mfr), 32'd0);
    endtask

    task automatic t_plain;
        logic [31:0] gid; logic [7:0] gm; int b, n;
        m_mfr = 32'h1234_5601;
        m_dev = 32'hBEEF_227E;
        m_ehi = 32'h0;
        m_elo = 32'h0;
        run(0, 0, gid, gm, b, n);
        chk("R3 mfr low byte", 32'(gm), 32'h01);
        chk("R6 id no escape", gid, lane0(m_dev));
        check_seq(b, n, 0);
    endtask

    task automatic t_escape;
        logic [31:0] gid; logic [7:0] gm; int b, n;
        m_mfr = 32'h0000_00C2;
        m_dev = 32'hFFFF_007E;
        m_ehi = 32'h1122_3344;
        m_elo = 32'h0000_00AB;
        run(2, 0, gid, gm, b, n);
        chk("R4 R5 extended id", gid, 32'h007E_44AB);
        chk("R3 mfr", 32'(gm), 32'hC2);
        check_seq(b, n, 1);
    endtask

    task automatic t_waits;
        logic [31:0] gid; logic [7:0] gm; int b, n;
        m_mfr = 32'hAAAA_0089;
        m_dev = 32'h5555_8819;
        run(5, 0, gid, gm, b, n);
        chk("R4 masked id", gid, 32'h0000_8819);
        chk("R3 mfr", 32'(gm), 32'h89);
        check_seq(b, n, 0);
        chk("R8 hold while pending", 32'(hold_err), 32'd0);
        chk("R8 strobe exclusive", 32'(excl_err), 32'd0);
    endtask

    task automatic t_busy_start;
        logic [31:0] gid; logic [7:0] gm; int b, n;
        m_mfr = 32'h0000_0020;
        m_dev = 32'h0000_00E3;
        run(1, 1, gid, gm, b, n);
        chk("R6 id", gid, 32'h0000_00E3);
        repeat (12) @(negedge clk);
        chk("R10 no second run busy", 32'(busy), 32'd0);
        chk("R10 no extra transactions", 32'(lg_n - b), 32'd6);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        m_mfr = '0; m_dev = '0; m_ehi = '0; m_elo = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_plain();
        t_escape();
        t_waits();
        t_busy_start();
        t_plain();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule